// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, for use at the fetch stage of a pipelined core. It keeps a table of two-bit saturating counters. The table has no tags. A table slot is chosen by XOR-ing a slice of the branch address with a global history register that records the outcomes of recent branches. The address slice skips the two low byte-offset bits. Because of the XOR, one branch can use different counters under different recent histories, and unrelated branches can land on the same counter. That sharing is accepted: a wrong guess costs performance, never correctness.

Fetch presents an address on the lookup port. One cycle later the block returns the taken/not-taken guess together with the history value used to form the slot. Fetch carries that history alongside the branch. When the branch resolves, the core presents three things on the update port: the branch address, the real outcome, and the history that was carried. The addressed counter then moves one step, and the outcome is shifted into the global history.

Each counter is a four-state machine: `CTR_SNT` (0, strongly not-taken), `CTR_WNT` (1, weakly not-taken), `CTR_WT` (2, weakly taken) and `CTR_ST` (3, strongly taken). The machine has two transition rules:
- A taken outcome moves SNT→WNT, WNT→WT, WT→ST, and ST→ST (held).
- A not-taken outcome moves ST→WT, WT→WNT, WNT→SNT, and SNT→SNT (held).

Top module: `gsp_predictor`

## Requirements
- R1: Reset behaviour.
  - Reset puts every counter at weakly not-taken (1) and clears the history to all zeros.
  - A lookup right after reset therefore returns not-taken and a reported history of 0.
- R2: Lookup timing.
  - `pr_valid` is high in exactly the cycle after a cycle with `lk_valid` high.
  - It is low otherwise.
- R3: Guess encoding.
  - `pr_taken` is 1 when the selected counter held 2 or 3, and 0 when it held 0 or 1.
  - `pr_taken` is 0 whenever `pr_valid` is 0.
- R4: Saturation at the top. A taken update adds one to the counter and saturates at 3. After many taken updates, a single not-taken update leaves the guess at taken, and a second one turns it to not-taken.
- R5: Saturation at the bottom. A not-taken update subtracts one and saturates at 0. From 0, the guess turns to taken only after the second taken update.
- R6: Slot selection.
  - The slot index is address bits [9:2] XOR the 8-bit history.
  - A lookup uses the live history; an update uses the history given on `up_hist`.
  - Address bits [1:0] and [31:10] have no effect on the index.
- R7: History shift. Each valid update shifts the history left by one bit, with the outcome entering bit 0 (1 = taken, 0 = not-taken).
- R8: History reporting. `pr_hist` reports the history value that was live in the lookup cycle.
- R9: Same-cycle collision. When an update and a lookup address the same slot in the same cycle, the lookup returns the counter value from before the update.
- R10: Aliasing. Two addresses that differ only above bit 9, looked up under the same history, share one counter.
- R11: Idle update port. With `up_valid` low, the values on `up_pc`, `up_taken` and `up_hist` change neither any counter nor the history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | 32 | Fetch address to predict |
| pr_valid | output | 1 | Guess is present (one cycle after lookup) |
| pr_taken | output | 1 | Guess: 1 = taken |
| pr_hist | output | 8 | History used to form the lookup index |
| up_valid | input | 1 | Resolved-branch update this cycle |
| up_pc | input | 32 | Address of the resolved branch |
| up_taken | input | 1 | Real outcome: 1 = taken |
| up_hist | input | 8 | History that was carried from the lookup |

## Verification
The assertions take for granted two things about the inputs. First, `lk_valid` and `up_valid` are 0 or 1 and never unknown. Second, both are held low while reset is asserted, so that the first guess and the first history shift can only follow a real request. The stimulus meets these conditions in three ways:
- It drives every input to a known value before releasing reset.
- It changes inputs only on the falling clock edge.
- It keeps both valid strobes low until reset is released, and it deasserts them at the end of each scenario.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    // Two-bit saturating counter states
    typedef enum logic [1:0] {
        CTR_SNT = 2'd0,
        CTR_WNT = 2'd1,
        CTR_WT  = 2'd2,
        CTR_ST  = 2'd3
    } ctr_t;

    localparam ctr_t CTR_RESET = CTR_WNT;

endpackage

// File: rtl/gsp_ctr_step.sv
module gsp_ctr_step
    import gsp_pkg::*;
(
    input  ctr_t cur,
    input  logic taken,
    output ctr_t nxt
);

    always_comb begin
        nxt = cur;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
        endcase
    end

endmodule

// File: rtl/gsp_index.sv
module gsp_index #(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);

    localparam int LO = 2;
    localparam int HI = IDX_W + LO - 1;

    logic [IDX_W-1:0] hist_ext;
    logic             unused_pc_bits;

    assign hist_ext       = IDX_W'(hist);
    assign idx            = pc[HI:LO] ^ hist_ext;
    assign unused_pc_bits = ^{pc[PC_W-1:HI+1], pc[LO-1:0]};

endmodule

// File: rtl/gsp_history.sv
module gsp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_in,
    output logic [HIST_W-1:0] hist_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_in};
        end
    end

endmodule

// File: rtl/gsp_table.sv
module gsp_table
    import gsp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_q,
    input  logic [IDX_W-1:0] wr_idx,
    output ctr_t             wr_cur,
    input  logic             wr_en,
    input  ctr_t             wr_data
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t ent_q [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q[e] <= CTR_RESET;
            end else if (wr_en && (wr_idx == IDX_W'(e))) begin
                ent_q[e] <= wr_data;
            end
        end
    end

    // Registered read samples the pre-write value on a collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= CTR_RESET;
        end else if (rd_en) begin
            rd_q <= ent_q[rd_idx];
        end
    end

    assign wr_cur = ent_q[wr_idx];

endmodule

// File: rtl/gsp_predictor.sv
module gsp_predictor
    import gsp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 8,
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              pr_valid,
    output logic              pr_taken,
    output logic [HIST_W-1:0] pr_hist,
    input  logic              up_valid,
    input  logic [PC_W-1:0]   up_pc,
    input  logic              up_taken,
    input  logic [HIST_W-1:0] up_hist
);

    logic [HIST_W-1:0] ghr_q;
    logic [IDX_W-1:0]  lk_idx;
    logic [IDX_W-1:0]  up_idx;
    ctr_t              rd_q;
    ctr_t              up_cur;
    ctr_t              up_nxt;

    gsp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_lk_index (
        .pc   (lk_pc),
        .hist (ghr_q),
        .idx  (lk_idx)
    );

    gsp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) u_up_index (
        .pc   (up_pc),
        .hist (up_hist),
        .idx  (up_idx)
    );

    gsp_table #(.IDX_W(IDX_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (lk_valid),
        .rd_idx  (lk_idx),
        .rd_q    (rd_q),
        .wr_idx  (up_idx),
        .wr_cur  (up_cur),
        .wr_en   (up_valid),
        .wr_data (up_nxt)
    );

    gsp_ctr_step u_step (
        .cur   (up_cur),
        .taken (up_taken),
        .nxt   (up_nxt)
    );

    gsp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (up_valid),
        .bit_in   (up_taken),
        .hist_q   (ghr_q)
    );

    // Response register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pr_valid <= 1'b0;
            pr_hist  <= '0;
        end else begin
            pr_valid <= lk_valid;
            if (lk_valid) begin
                pr_hist <= ghr_q;
            end
        end
    end

    // Output decode
    always_comb begin
        pr_taken = 1'b0;
        if (pr_valid) begin
            unique case (rd_q)
                CTR_SNT, CTR_WNT: pr_taken = 1'b0;
                CTR_WT,  CTR_ST:  pr_taken = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/gsp_predictor_chk.sv
module gsp_predictor_chk #(
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              up_valid,
    input logic              up_taken,
    input logic              pr_valid,
    input logic              pr_taken,
    input logic [HIST_W-1:0] pr_hist,
    input logic [HIST_W-1:0] ghr
);

    a_r1_hist_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ghr == '0);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> pr_valid == $past(lk_valid));

    a_r3_taken_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !pr_valid |-> !pr_taken);

    a_r7_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> ghr == {$past(ghr[HIST_W-2:0]), $past(up_taken)});

    a_r8_hist_report: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> pr_hist == $past(ghr));

    a_r11_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(ghr));

endmodule

bind gsp_predictor gsp_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .up_valid (up_valid),
    .up_taken (up_taken),
    .pr_valid (pr_valid),
    .pr_taken (pr_taken),
    .pr_hist  (pr_hist),
    .ghr      (ghr_q)
);

// File: tb/gsp_predictor_bench.sv
`timescale 1ns/1ps
module gsp_predictor_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        pr_valid;
    logic        pr_taken;
    logic [7:0]  pr_hist;
    logic        up_valid = 1'b0;
    logic [31:0] up_pc = '0;
    logic        up_taken = 1'b0;
    logic [7:0]  up_hist = '0;

    int total = 0;
    int bad   = 0;

    int unsigned mdl [256];
    logic [7:0]  ghr_m;

    always #2.5 clk = ~clk;

    gsp_predictor u_gsp_predictor (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_valid (lk_valid),
        .lk_pc    (lk_pc),
        .pr_valid (pr_valid),
        .pr_taken (pr_taken),
        .pr_hist  (pr_hist),
        .up_valid (up_valid),
        .up_pc    (up_pc),
        .up_taken (up_taken),
        .up_hist  (up_hist)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    function automatic logic [7:0] idx_of(input logic [31:0] pc, input logic [7:0] h);
        return pc[9:2] ^ h;
    endfunction

    // Address that hits entry e under the live history
    function automatic logic [31:0] pc_for(input logic [7:0] e, input logic [21:0] hi,
                                           input logic [1:0] lo);
        return {hi, e ^ ghr_m, lo};
    endfunction

    // One cycle; inputs driven at a falling edge, outputs checked at the next
    task automatic step(input bit lkv, input logic [31:0] lkpc,
                        input bit upv, input logic [31:0] uppc,
                        input bit upt, input logic [7:0] uph,
                        input string rq, output bit got);
        bit         exp_t;
        logic [7:0] exp_h;
        logic [7:0] ui;
        lk_valid = lkv; lk_pc = lkpc;
        up_valid = upv; up_pc = uppc; up_taken = upt; up_hist = uph;
        exp_t = lkv && (mdl[idx_of(lkpc, ghr_m)] >= 2);
        exp_h = ghr_m;
        if (upv) begin
            ui = idx_of(uppc, uph);
            if (upt && mdl[ui] < 3) mdl[ui]++;
            if (!upt && mdl[ui] > 0) mdl[ui]--;
            ghr_m = {ghr_m[6:0], upt};
        end
        @(negedge clk);
        if (lkv) begin
            check(pr_valid == 1'b1, "R2", "pr_valid after lookup", int'(pr_valid), 1);
            check(pr_taken == exp_t, rq, "pr_taken", int'(pr_taken), int'(exp_t));
            check(pr_hist == exp_h, "R8", "pr_hist", int'(pr_hist), int'(exp_h));
        end else begin
            check(pr_valid == 1'b0, "R2", "pr_valid idle", int'(pr_valid), 0);
            check(pr_taken == 1'b0, "R3", "pr_taken idle", int'(pr_taken), 0);
        end
        got = pr_taken;
        lk_valid = 1'b0;
        up_valid = 1'b0;
    endtask

    task automatic upd(input logic [31:0] pc, input bit t, input logic [7:0] h, input string rq);
        bit g;
        step(1'b0, '0, 1'b1, pc, t, h, rq, g);
    endtask

    task automatic probe(input logic [7:0] e, input string rq, input bit exp_t);
        bit g;
        step(1'b1, pc_for(e, 22'h0, 2'b00), 1'b0, '0, 1'b0, '0, rq, g);
        check(g == exp_t, rq, "directed guess", int'(g), int'(exp_t));
    endtask

    task automatic t_reset;
        bit g;
        probe(8'h00, "R1", 1'b0);
        check(pr_hist == 8'h00, "R1", "history after reset", int'(pr_hist), 0);
        probe(8'hFF, "R1", 1'b0);
        step(1'b0, '0, 1'b0, '0, 1'b0, '0, "R2", g);
    endtask

    task automatic t_saturate_up;
        for (int i = 0; i < 5; i++) upd({22'h0, 8'h35, 2'b00}, 1'b1, 8'h00, "R4");
        probe(8'h35, "R3", 1'b1);
        upd({22'h0, 8'h35, 2'b00}, 1'b0, 8'h00, "R4");
        probe(8'h35, "R4", 1'b1);
        upd({22'h0, 8'h35, 2'b00}, 1'b0, 8'h00, "R4");
        probe(8'h35, "R4", 1'b0);
    endtask

    task automatic t_saturate_down;
        for (int i = 0; i < 4; i++) upd({22'h0, 8'h35, 2'b00}, 1'b0, 8'h00, "R5");
        upd({22'h0, 8'h35, 2'b00}, 1'b1, 8'h00, "R5");
        probe(8'h35, "R5", 1'b0);
        upd({22'h0, 8'h35, 2'b00}, 1'b1, 8'h00, "R5");
        probe(8'h35, "R5", 1'b1);
    endtask

    task automatic t_index;
        bit g;
        // 0x5A ^ 0x0F = 0x55, upper and low address bits are noise
        upd({22'h3FFFFF, 8'h5A, 2'b11}, 1'b1, 8'h0F, "R6");
        step(1'b1, pc_for(8'h55, 22'h123, 2'b10), 1'b0, '0, 1'b0, '0, "R6", g);
        check(g == 1'b1, "R6", "xor-selected entry", int'(g), 1);
        probe(8'h5A, "R6", 1'b0);
    endtask

    task automatic t_alias;
        bit g;
        upd({22'h000001, 8'h10, 2'b00}, 1'b1, 8'h00, "R10");
        step(1'b1, pc_for(8'h10, 22'h2AAAA, 2'b01), 1'b0, '0, 1'b0, '0, "R10", g);
        check(g == 1'b1, "R10", "aliased address shares counter", int'(g), 1);
    endtask

    task automatic t_hist;
        bit pat [8] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};
        for (int i = 0; i < 8; i++) upd({22'h0, 8'hC0, 2'b00}, pat[i], 8'h00, "R7");
        probe(8'hE1, "R7", 1'b0);
        check(pr_hist == 8'hB2, "R7", "history pattern", int'(pr_hist), 8'hB2);
    endtask

    task automatic t_same_cycle;
        bit g;
        step(1'b1, pc_for(8'h77, 22'h0, 2'b00), 1'b1, {22'h0, 8'h77, 2'b00}, 1'b1, 8'h00, "R9", g);
        check(g == 1'b0, "R9", "collision returns old value", int'(g), 0);
        probe(8'h77, "R9", 1'b1);
    endtask

    task automatic t_no_update;
        bit g;
        logic [7:0] h0;
        h0 = ghr_m;
        lk_valid = 1'b0;
        up_valid = 1'b0; up_pc = {22'h0, 8'h88, 2'b00}; up_taken = 1'b1; up_hist = 8'h00;
        @(negedge clk);
        @(negedge clk);
        step(1'b1, pc_for(8'h88 ^ h0 ^ ghr_m, 22'h0, 2'b00), 1'b0, '0, 1'b0, '0, "R11", g);
        check(g == 1'b0, "R11", "counter untouched", int'(g), 0);
        check(pr_hist == h0, "R11", "history untouched", int'(pr_hist), int'(h0));
        probe(8'h88, "R11", 1'b0);
    endtask

    task automatic t_stream;
        logic [15:0] lf = 16'hACE1;
        bit g;
        for (int i = 0; i < 400; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], {lf[15:0], lf[7:0], lf[13:6]}, lf[1],
                 {lf[7:0], lf[15:0], lf[11:4]}, lf[2] | lf[3], lf[12:5], "R3", g);
        end
    endtask

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mdl[i] = 1;
        ghr_m = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_saturate_up();
        t_saturate_down();
        t_index();
        t_alias();
        t_hist();
        t_same_cycle();
        t_no_update();
        t_stream();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule